// File: doc/BRIEF.md
# Bootloop Ones-Count Masker

This block takes the good-loop bitmap of one formatter as a byte stream and trims it so that exactly a fixed number of set bits survive. A frame is 40 map bytes followed by one terminator byte that must be zero. The block scans bits least significant first and bytes in arrival order. It copies every set bit until the target count has been reached and clears every set bit after that. Zero bits always stay zero. The 40 masked bytes leave on an output stream. The terminator byte is consumed and is not forwarded.

The target is 270 kept ones when the error-correction enable is high and 272 when it is low. The enable is sampled with the first byte of each frame. When the terminator is accepted, the block pulses a frame-end strobe and updates three held flags: target reached, shortfall (fewer ones than the target were present) and format error (the terminator byte was nonzero). Both sides use a valid/ready handshake and are one byte wide.

Top module: `bl_ones_masker`

## Requirements
- R1: With the enable sampled high, the first 270 set bits of a frame are kept and all later set bits are cleared.
- R2: With the enable sampled low, the first 272 set bits of a frame are kept and all later set bits are cleared.
- R3: Bit scan order is bit 0 to bit 7 within a byte, and byte order is arrival order. Output byte k is the masked form of input byte k.
- R4: An output byte never has a 1 where the matching input byte had a 0.
- R5: The 41st byte of a frame produces no output byte. If it is nonzero, fmt_err is 1 after the frame ends; if it is zero, fmt_err is 0.
- R6: At frame end, target_met is 1 and shortfall is 0 when the kept count equals the target. Otherwise target_met is 0 and shortfall is 1. Exactly one of the two flags is set.
- R7: The kept count restarts at zero with each frame. The enable is taken only from the cycle that accepts the frame's first byte, and later changes within the frame have no effect.
- R8: While out_valid is 1 and out_ready is 0, out_data is held stable and in_ready is 0.
- R9: After reset, out_valid, frame_done, target_met, shortfall and fmt_err are 0 and in_ready is 1.
- R10: frame_done is a single-cycle pulse that appears in the cycle after the terminator byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_en | input | 1 | Error-correction enable, sampled with the first byte of a frame |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Input map byte or terminator |
| out_valid | output | 1 | Masked byte valid |
| out_ready | input | 1 | Sink accepts the masked byte |
| out_data | output | 8 | Masked map byte |
| frame_done | output | 1 | One-cycle frame-end strobe |
| target_met | output | 1 | Kept count equalled the target in the last frame |
| shortfall | output | 1 | Fewer ones than the target in the last frame |
| fmt_err | output | 1 | Terminator of the last frame was nonzero |

## Verification
A byte accepted at a clock edge appears as a masked byte right after that edge. The frame-end pulse and the flags update right after the edge that accepts the terminator. The bench drives both handshakes at the falling edge and samples one time unit later. It records which bytes were accepted in each cycle, so it can compare each output with the model at the handshake and require the strobe exactly one loop iteration after the terminator handshake. Expected bytes and flags come from a bit-serial count in the bench. Frames are swept over 256 byte seeds, some with a stalling sink.

// File: rtl/bl_mask_pkg.sv
package bl_mask_pkg;
    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned MAP_BYTES    = 40;
    localparam int unsigned KEEP_WITH_EC = 270;
    localparam int unsigned KEEP_NO_EC   = 272;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/bl_keep_byte.sv
module bl_keep_byte #(
    parameter int unsigned BW = 8,
    parameter int unsigned CW = 9
) (
    input  logic [BW-1:0] din,
    input  logic [CW-1:0] budget,
    output logic [BW-1:0] dout,
    output logic [CW-1:0] nkept
);
    logic [CW-1:0] run [BW+1];

    assign run[0] = '0;

    for (genvar i = 0; i < BW; i++) begin : g_bit
        logic keep_i;
        assign keep_i     = din[i] && (run[i] < budget);
        assign dout[i]    = keep_i;
        assign run[i+1]   = run[i] + CW'(keep_i);
    end

    assign nkept = run[BW];
endmodule

// File: rtl/bl_zero_check.sv
module bl_zero_check #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] val,
    output logic         is_zero
);
    assign is_zero = ~|val;
endmodule

// File: rtl/bl_ones_masker.sv
module bl_ones_masker
    import bl_mask_pkg::*;
#(
    parameter int unsigned DATA_BYTES = MAP_BYTES,
    parameter int unsigned KEEP_ECC   = KEEP_WITH_EC,
    parameter int unsigned KEEP_RAW   = KEEP_NO_EC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              frame_done,
    output logic              target_met,
    output logic              shortfall,
    output logic              fmt_err
);
    localparam int unsigned CW = cnt_width(DATA_BYTES * BYTE_W);
    localparam int unsigned IW = cnt_width(DATA_BYTES);
    localparam logic [CW-1:0] TGT_ECC = CW'(KEEP_ECC);
    localparam logic [CW-1:0] TGT_RAW = CW'(KEEP_RAW);
    localparam logic [IW-1:0] TERM_IDX = IW'(DATA_BYTES);

    typedef struct packed {
        logic [IW-1:0]     idx;
        logic [CW-1:0]     kept;
        logic              ecc;
        logic              ov;
        logic [BYTE_W-1:0] od;
        logic              done;
        logic              met;
        logic              sh;
        logic              fe;
    } state_t;

    state_t st_q, st_d;

    logic              accept;
    logic              is_term;
    logic              first_byte;
    logic              ecc_eff;
    logic [CW-1:0]     target;
    logic [CW-1:0]     kept_base;
    logic [CW-1:0]     budget;
    logic [BYTE_W-1:0] masked;
    logic [CW-1:0]     nkept;
    logic              term_zero;

    assign in_ready   = !st_q.ov || out_ready;
    assign accept     = in_valid && in_ready;
    assign is_term    = (st_q.idx == TERM_IDX);
    assign first_byte = (st_q.idx == '0);
    assign ecc_eff    = first_byte ? ecc_en : st_q.ecc;
    assign target     = ecc_eff ? TGT_ECC : TGT_RAW;
    assign kept_base  = first_byte ? '0 : st_q.kept;
    assign budget     = target - kept_base;

    bl_keep_byte #(.BW(BYTE_W), .CW(CW)) u_keep (
        .din    (in_data),
        .budget (budget),
        .dout   (masked),
        .nkept  (nkept)
    );

    bl_zero_check #(.W(BYTE_W)) u_term (
        .val     (in_data),
        .is_zero (term_zero)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.ov && out_ready) begin
            st_d.ov = 1'b0;
        end
        if (accept) begin
            if (!is_term) begin
                st_d.ov   = 1'b1;
                st_d.od   = masked;
                st_d.kept = kept_base + nkept;
                st_d.idx  = st_q.idx + 1'b1;
                st_d.ecc  = ecc_eff;
            end else begin
                st_d.idx  = '0;
                st_d.done = 1'b1;
                st_d.met  = (st_q.kept == target);
                st_d.sh   = (st_q.kept != target);
                st_d.fe   = !term_zero;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.ov;
    assign out_data   = st_q.od;
    assign frame_done = st_q.done;
    assign target_met = st_q.met;
    assign shortfall  = st_q.sh;
    assign fmt_err    = st_q.fe;
endmodule

// File: rtl/bl_ones_masker_chk.sv
module bl_ones_masker_chk #(
    parameter int unsigned DATA_BYTES = 40,
    parameter int unsigned KEEP_ECC   = 270,
    parameter int unsigned KEEP_RAW   = 272,
    parameter int unsigned IW         = 6,
    parameter int unsigned CW         = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [7:0]    in_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          frame_done,
    input logic          target_met,
    input logic          shortfall,
    input logic [IW-1:0] idx,
    input logic [CW-1:0] kept,
    input logic          ecc
);
    // R4
    keep_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && idx != IW'(DATA_BYTES)) |=>
        (out_valid && ((out_data & ~$past(in_data)) == 8'h00)));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8
    in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R5
    term_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && idx == IW'(DATA_BYTES)) |=> frame_done);

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (target_met != shortfall));

    // R1
    kept_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0) |-> (kept <= (ecc ? CW'(KEEP_ECC) : CW'(KEEP_RAW))));
endmodule

bind bl_ones_masker bl_ones_masker_chk #(
    .DATA_BYTES (DATA_BYTES),
    .KEEP_ECC   (KEEP_ECC),
    .KEEP_RAW   (KEEP_RAW),
    .IW         (IW),
    .CW         (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .frame_done (frame_done),
    .target_met (target_met),
    .shortfall  (shortfall),
    .idx        (st_q.idx),
    .kept       (st_q.kept),
    .ecc        (st_q.ecc)
);

// File: tb/sim_bl_ones_masker.sv
module sim_bl_ones_masker;
    localparam int CLK_PERIOD = 10;
    localparam int DB   = 40;
    localparam int K_EC = 270;
    localparam int K_NO = 272;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ecc_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       frame_done, target_met, shortfall, fmt_err;

    int errors = 0;
    int checks = 0;

    logic [7:0] fr   [DB];
    logic [7:0] expb [DB];
    logic       emet, esh;

    always #(CLK_PERIOD/2) clk = ~clk;

    bl_ones_masker u0 (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .frame_done(frame_done), .target_met(target_met),
        .shortfall(shortfall), .fmt_err(fmt_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input int target);
        int cnt = 0;
        for (int b = 0; b < DB; b++) begin
            expb[b] = 8'h00;
            for (int i = 0; i < 8; i++) begin
                if (fr[b][i] && cnt < target) begin
                    expb[b][i] = 1'b1;
                    cnt++;
                end
            end
        end
        emet = (cnt == target);
        esh  = (cnt != target);
    endtask

    task automatic run_frame(input logic [7:0] term, input bit ecc0,
                             input bit stall, input bit toggle);
        int sent = 0;
        int rx = 0;
        int cyc = 0;
        int term_cyc = -10;
        bit got_done = 0;
        bit fi;
        model(ecc0 ? K_EC : K_NO);
        while (!(got_done && rx == DB) && cyc < 400) begin
            out_ready = stall ? cyc[0] : 1'b1;
            if (sent <= DB) begin
                in_valid = 1'b1;
                in_data  = (sent < DB) ? fr[sent] : term;
                ecc_en   = (sent == 0) ? ecc0 : (toggle ? ~ecc0 : ecc0);
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (frame_done) begin
                got_done = 1;
                chk(term_cyc == cyc - 1, "R10 done timing", cyc, term_cyc + 1);
                chk(target_met == emet, "R6 target_met", target_met, emet);
                chk(shortfall == esh, "R6 shortfall", shortfall, esh);
                chk(fmt_err == (term != 8'h00), "R5 fmt_err", fmt_err, term != 8'h00);
            end
            if (out_valid && out_ready) begin
                if (rx < DB) begin
                    // R1 R2 R3 R4 R7: byte-by-byte against the model
                    chk(out_data == expb[rx], ecc0 ? "R1 R3 R4 R7 byte" : "R2 R3 R4 R7 byte",
                        out_data, expb[rx]);
                end else begin
                    chk(0, "R5 extra output byte", rx, DB);
                end
                rx++;
            end
            fi = in_valid && in_ready;
            @(posedge clk);
            @(negedge clk);
            if (fi) begin
                if (sent == DB) term_cyc = cyc;
                sent++;
            end
            cyc++;
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        chk(rx == DB, "R5 output byte count", rx, DB);
        chk(got_done, "R10 frame_done seen", got_done, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9
        chk(out_valid == 0, "R9 out_valid", out_valid, 0);
        chk(frame_done == 0, "R9 frame_done", frame_done, 0);
        chk({target_met, shortfall, fmt_err} == 3'b000, "R9 flags",
            {target_met, shortfall, fmt_err}, 0);
        chk(in_ready == 1, "R9 in_ready", in_ready, 1);
        @(negedge clk);

        // R1: all ones, correction on -> 270 kept
        for (int b = 0; b < DB; b++) fr[b] = 8'hFF;
        run_frame(8'h00, 1'b1, 1'b0, 1'b0);
        // R7: same frame again, count restarts
        run_frame(8'h00, 1'b1, 1'b1, 1'b0);
        // R2: all ones, correction off -> 272 kept
        run_frame(8'h00, 1'b0, 1'b0, 1'b0);
        // R7: enable flips after first byte; first-byte value rules
        run_frame(8'h00, 1'b0, 1'b0, 1'b1);
        run_frame(8'h00, 1'b1, 1'b1, 1'b1);

        // R1 R6: exactly 270 ones
        for (int b = 0; b < DB; b++) fr[b] = (b < 33) ? 8'hFF : 8'h00;
        fr[33] = 8'h3F;
        run_frame(8'h00, 1'b1, 1'b0, 1'b0);
        // R2 R6: 270 ones without correction -> shortfall
        run_frame(8'h00, 1'b0, 1'b0, 1'b0);
        // R1: 271 ones, one trimmed
        fr[33] = 8'h7F;
        run_frame(8'h00, 1'b1, 1'b0, 1'b0);
        // R5: nonzero terminator
        run_frame(8'h80, 1'b1, 1'b0, 1'b0);
        run_frame(8'h00, 1'b1, 1'b0, 1'b0);

        // Sweep of byte seeds, correction and stall varied
        for (int v = 0; v < 256; v++) begin
            for (int b = 0; b < DB; b++) fr[b] = 8'((v | (b * 37)) ^ (b < 20 ? 8'h00 : 8'(v)));
            run_frame((v % 64 == 9) ? 8'(v) : 8'h00, v[0], v[1] & v[2], v[3] & v[4]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule